// File: doc/BRIEF.md
# Deferred Transaction Tracker

This block keeps track of non-postable requests, such as I/O writes and configuration writes, that a bridge accepts with a retry and then finishes on the far side. It has a small in-order queue. Each slot holds the address, the command, one doubleword of write data, the active-low byte enables and a parity bit. A request that does not match a stored entry is always answered with retry. It is stored if the queue has room and no entry already holds the same address and command. The oldest entry goes to the target side once an ordering input allows it. It is re-sent on each target retry and gives up after a fixed number of failed attempts.

Once the target side finishes (or the attempt budget runs out), the oldest entry waits for the initiator to repeat its request. A repeat that matches the entry in address, command and byte enables, and in data on every enabled byte of a write, collects the result. It gets data-ready, or data-ready with stop when it asks for more than one doubleword, or target abort if the attempts ran out. A discard timer removes a result that is never collected. Abort and discard both pulse a system-error output when that output is enabled.

The oldest entry moves through named states. EMPTY is the state with no entry. HOLD means the entry is waiting for the ordering input. ISSUE means a request is on the target side. DONE_OK means the entry completed and waits for collection. DONE_ABORT means the attempt budget is spent and the entry waits for collection.

The transitions are:
- EMPTY to HOLD when an entry is present.
- HOLD to ISSUE when the ordering input is high.
- ISSUE to DONE_OK on a target completion.
- ISSUE back to HOLD on a target retry with budget left.
- ISSUE to DONE_ABORT on the last allowed retry.
- DONE_OK or DONE_ABORT to EMPTY on collection or on discard.

Top module: `deferred_txn_queue`

## Requirements
- R1: After reset there is no response (`rsp_valid`=0), no target request (`tgt_req`=0), no `serr` pulse, and the queue is empty.
- R2: Each pulse on `req_valid` gets exactly one response with `rsp_valid`=1 on the next cycle. A request that does not collect the oldest entry is answered with code 00 (retry). Such a request is stored when fewer than four entries are held and no entry has the same address and command.
- R3: When four entries are held, a new request is still answered with retry and is not stored.
- R4: A request whose address and command equal those of a held entry creates no new entry. If that entry is not collectable, the answer is retry.
- R5: Only the oldest entry is offered on the target side, in arrival order. `tgt_req` rises only after `order_ok` was high. The entry's address, command, data, byte enables and parity are presented unchanged. `tgt_req` stays high until `tgt_rsp_valid`.
- R6: A target response with `tgt_rsp_retry`=1 re-sends the entry after it passes HOLD again. The 2^RETRY_W-th consecutive failed attempt ends the attempts and pulses `serr` when `serr_en`=1. The next matching repeat gets code 11 (target abort) and removes the entry.
- R7: After a target response with `tgt_rsp_retry`=0, a matching repeat gets code 01 (data-ready) when `req_multi`=0, or code 10 (data-ready with stop) when `req_multi`=1. The entry is then removed.
- R8: A repeat matches when address, command and `req_be_n` are equal. For a write command (`req_cmd[0]`=1), data must also be equal on each byte i with `req_be_n[i]`=0, where byte i is data bits [8i+7:8i]. A read command (`req_cmd[0]`=0) is not compared on data.
- R9: A repeat that differs from a completed entry in an enabled data byte is answered with retry and leaves the entry collectable.
- R10: A completed or aborted oldest entry is discarded after 2^DISCARD_LONG_W cycles without collection, or after 2^DISCARD_SHORT_W cycles when `discard_short`=1. A later request for it is treated as new.
- R11: `serr` pulses for one cycle on an abort or a discard only if `serr_en` was 1 in the cycle of the event. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serr_en | input | 1 | Enables the system-error pulse |
| discard_short | input | 1 | Selects the short discard period |
| order_ok | input | 1 | Posted-write ordering allows the oldest entry to go out |
| req_valid | input | 1 | One-cycle pulse: an initiator request is present |
| req_addr | input | AW | Request address |
| req_cmd | input | 4 | Request command; bit 0 set means write |
| req_data | input | 32 | Request write data |
| req_be_n | input | 4 | Active-low byte enables |
| req_par | input | 1 | Parity bit stored with the entry |
| req_multi | input | 1 | Initiator wants more than one doubleword |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 retry, 01 data-ready, 10 data-ready with stop, 11 target abort |
| tgt_req | output | 1 | Oldest entry is being offered to the target side |
| tgt_addr | output | AW | Address of the offered entry |
| tgt_cmd | output | 4 | Command of the offered entry |
| tgt_data | output | 32 | Data of the offered entry |
| tgt_be_n | output | 4 | Byte enables of the offered entry |
| tgt_par | output | 1 | Parity of the offered entry |
| tgt_rsp_valid | input | 1 | Target-side result present |
| tgt_rsp_retry | input | 1 | 1: target retried, 0: target completed |
| serr | output | 1 | One-cycle system-error pulse |

## Verification
The assertions assume that `tgt_rsp_valid` is only driven while `tgt_req` is high. They also assume that `req_valid` comes as single-cycle pulses. The stimulus keeps to both rules: it answers the target side only after it has seen `tgt_req`, and it raises `req_valid` for one cycle per request. The bench uses a reduced configuration with a budget of eight attempts and discard periods of 16 and 64 cycles. This makes the attempt limit and both timer settings reachable. It also sweeps all sixteen byte-enable patterns for the masked data compare.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

    typedef enum logic [1:0] {
        RSP_RETRY    = 2'b00,
        RSP_ACK      = 2'b01,
        RSP_ACK_STOP = 2'b10,
        RSP_ABORT    = 2'b11
    } rsp_e;

    typedef enum logic [2:0] {
        H_EMPTY,
        H_HOLD,
        H_ISSUE,
        H_DONE_OK,
        H_DONE_ABORT
    } head_e;

endpackage

// File: rtl/dtq_store.sv
module dtq_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [3:0]    push_cmd,
    input  logic [31:0]   push_data,
    input  logic [3:0]    push_be_n,
    input  logic          push_par,
    input  logic          pop,
    input  logic [AW-1:0] chk_addr,
    input  logic [3:0]    chk_cmd,
    input  logic [31:0]   chk_data,
    input  logic [3:0]    chk_be_n,
    output logic          empty,
    output logic          full,
    output logic          dup_hit,
    output logic          head_hit,
    output logic [AW-1:0] head_addr,
    output logic [3:0]    head_cmd,
    output logic [31:0]   head_data,
    output logic [3:0]    head_be_n,
    output logic          head_par
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]    hd_q, tl_q;
    logic [CW-1:0]    cnt_q;
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] slot_dup;
    logic [31:0]      en_mask;

    logic [AW-1:0] addr_q [DEPTH];
    logic [3:0]    cmd_q  [DEPTH];
    logic [31:0]   data_q [DEPTH];
    logic [3:0]    be_q   [DEPTH];
    logic          par_q  [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
            vld_q <= '0;
        end else begin
            if (push) begin
                vld_q[tl_q] <= 1'b1;
                tl_q        <= bump(tl_q);
            end
            if (pop) begin
                vld_q[hd_q] <= 1'b0;
                hd_q        <= bump(hd_q);
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tl_q] <= push_addr;
            cmd_q[tl_q]  <= push_cmd;
            data_q[tl_q] <= push_data;
            be_q[tl_q]   <= push_be_n;
            par_q[tl_q]  <= push_par;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            assign slot_dup[i] = vld_q[i] && (addr_q[i] == chk_addr) && (cmd_q[i] == chk_cmd);
        end
    endgenerate

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            en_mask[8*b +: 8] = {8{~chk_be_n[b]}};
        end
    end

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));
    assign dup_hit   = |slot_dup;
    assign head_addr = addr_q[hd_q];
    assign head_cmd  = cmd_q[hd_q];
    assign head_data = data_q[hd_q];
    assign head_be_n = be_q[hd_q];
    assign head_par  = par_q[hd_q];
    assign head_hit  = vld_q[hd_q] && (head_addr == chk_addr) && (head_cmd == chk_cmd)
                    && (head_be_n == chk_be_n)
                    && (!chk_cmd[0] || (((head_data ^ chk_data) & en_mask) == 32'h0));

    // R3: a store never happens into a full queue
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R2: removal only from a non-empty queue
    a_r2_pop_has_entry: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/dtq_head_fsm.sv
module dtq_head_fsm
    import dtq_pkg::*;
#(
    parameter int RETRY_W = 24,
    parameter int LONG_W  = 15,
    parameter int SHORT_W = 10
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  head_present,
    input  logic  order_ok,
    input  logic  tgt_rsp_valid,
    input  logic  tgt_rsp_retry,
    input  logic  collect,
    input  logic  discard_short,
    output head_e state,
    output logic  tgt_req,
    output logic  abort_evt,
    output logic  discard_evt
);

    localparam logic [LONG_W-1:0] LONG_LIM  = '1;
    localparam logic [LONG_W-1:0] SHORT_LIM = LONG_W'((2 ** SHORT_W) - 1);

    head_e               state_q, state_d;
    logic [RETRY_W-1:0]  att_q;
    logic [LONG_W-1:0]   tmr_q;
    logic [LONG_W-1:0]   lim;
    logic                done;

    assign lim  = discard_short ? SHORT_LIM : LONG_LIM;
    assign done = (state_q == H_DONE_OK) || (state_q == H_DONE_ABORT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= H_EMPTY;
            att_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == H_EMPTY)
                att_q <= '0;
            else if (tgt_req && tgt_rsp_valid && tgt_rsp_retry)
                att_q <= att_q + 1'b1;
            if (!done)
                tmr_q <= '0;
            else
                tmr_q <= tmr_q + 1'b1;
        end
    end

    always_comb begin
        tgt_req     = (state_q == H_ISSUE);
        abort_evt   = tgt_req && tgt_rsp_valid && tgt_rsp_retry && (&att_q);
        discard_evt = done && !collect && (tmr_q == lim);
        state       = state_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_EMPTY:      if (head_present) state_d = H_HOLD;
            H_HOLD:       if (order_ok) state_d = H_ISSUE;
            H_ISSUE: begin
                if (tgt_rsp_valid) begin
                    if (!tgt_rsp_retry) state_d = H_DONE_OK;
                    else if (abort_evt) state_d = H_DONE_ABORT;
                    else                state_d = H_HOLD;
                end
            end
            H_DONE_OK,
            H_DONE_ABORT: if (collect || discard_evt) state_d = H_EMPTY;
            default:      state_d = H_EMPTY;
        endcase
    end

    // R5: offer held until the target side answers
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && !tgt_rsp_valid |=> tgt_req);
    // R5: an offer starts only after ordering permission
    a_r5_issue_after_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_req) |-> $past(order_ok));
    // R6: the final failed attempt leaves the entry aborted
    a_r6_abort_lands: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> state_q == H_DONE_ABORT);

endmodule

// File: rtl/deferred_txn_queue.sv
module deferred_txn_queue
    import dtq_pkg::*;
#(
    parameter int DEPTH           = 4,
    parameter int AW              = 32,
    parameter int RETRY_W         = 24,
    parameter int DISCARD_LONG_W  = 15,
    parameter int DISCARD_SHORT_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          serr_en,
    input  logic          discard_short,
    input  logic          order_ok,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_cmd,
    input  logic [31:0]   req_data,
    input  logic [3:0]    req_be_n,
    input  logic          req_par,
    input  logic          req_multi,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic          tgt_req,
    output logic [AW-1:0] tgt_addr,
    output logic [3:0]    tgt_cmd,
    output logic [31:0]   tgt_data,
    output logic [3:0]    tgt_be_n,
    output logic          tgt_par,
    input  logic          tgt_rsp_valid,
    input  logic          tgt_rsp_retry,
    output logic          serr
);

    logic  empty, full, dup_hit, head_hit;
    logic  collect, push, pop;
    logic  abort_evt, discard_evt;
    head_e hstate;
    rsp_e  code_d;

    assign collect = req_valid && head_hit && ((hstate == H_DONE_OK) || (hstate == H_DONE_ABORT));
    assign push    = req_valid && !dup_hit && !full;
    assign pop     = collect || discard_evt;

    dtq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_addr),
        .push_cmd  (req_cmd),
        .push_data (req_data),
        .push_be_n (req_be_n),
        .push_par  (req_par),
        .pop       (pop),
        .chk_addr  (req_addr),
        .chk_cmd   (req_cmd),
        .chk_data  (req_data),
        .chk_be_n  (req_be_n),
        .empty     (empty),
        .full      (full),
        .dup_hit   (dup_hit),
        .head_hit  (head_hit),
        .head_addr (tgt_addr),
        .head_cmd  (tgt_cmd),
        .head_data (tgt_data),
        .head_be_n (tgt_be_n),
        .head_par  (tgt_par)
    );

    dtq_head_fsm #(
        .RETRY_W (RETRY_W),
        .LONG_W  (DISCARD_LONG_W),
        .SHORT_W (DISCARD_SHORT_W)
    ) u_head (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_present  (!empty),
        .order_ok      (order_ok),
        .tgt_rsp_valid (tgt_rsp_valid),
        .tgt_rsp_retry (tgt_rsp_retry),
        .collect       (collect),
        .discard_short (discard_short),
        .state         (hstate),
        .tgt_req       (tgt_req),
        .abort_evt     (abort_evt),
        .discard_evt   (discard_evt)
    );

    always_comb begin
        code_d = RSP_RETRY;
        if (collect) begin
            if (hstate == H_DONE_ABORT) code_d = RSP_ABORT;
            else if (req_multi)         code_d = RSP_ACK_STOP;
            else                        code_d = RSP_ACK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_RETRY;
            serr      <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_code  <= code_d;
            serr      <= serr_en && (abort_evt || discard_evt);
        end
    end

    // R2: responses only follow requests
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    // R7: data-ready only for a completed oldest entry
    a_r7_ack_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_code == RSP_ACK || rsp_code == RSP_ACK_STOP) |-> $past(hstate == H_DONE_OK));
    // R6: abort code only for an aborted oldest entry
    a_r6_abort_needs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_code == RSP_ABORT |-> $past(hstate == H_DONE_ABORT));
    // R11: error pulse only when enabled
    a_r11_serr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> $past(serr_en));

endmodule

// File: tb/deferred_txn_queue_bench.sv
module deferred_txn_queue_bench;

    localparam int AW = 16;
    localparam logic [3:0] IOW = 4'b0011;
    localparam logic [3:0] IOR = 4'b0010;
    localparam logic [3:0] CFW = 4'b1011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          serr_en = 1'b0, discard_short = 1'b0, order_ok = 1'b0;
    logic          req_valid = 1'b0, req_par = 1'b0, req_multi = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_cmd = '0, req_be_n = '0;
    logic [31:0]   req_data = '0;
    logic          rsp_valid, tgt_req, tgt_par, serr;
    logic [1:0]    rsp_code;
    logic [AW-1:0] tgt_addr;
    logic [3:0]    tgt_cmd, tgt_be_n;
    logic [31:0]   tgt_data;
    logic          tgt_rsp_valid = 1'b0, tgt_rsp_retry = 1'b0;

    int checks = 0;
    int fails = 0;
    int serr_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    deferred_txn_queue #(
        .DEPTH(4), .AW(AW), .RETRY_W(3), .DISCARD_LONG_W(6), .DISCARD_SHORT_W(4)
    ) u_deferred_txn_queue (
        .clk(clk), .rst_n(rst_n), .serr_en(serr_en), .discard_short(discard_short),
        .order_ok(order_ok), .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
        .req_data(req_data), .req_be_n(req_be_n), .req_par(req_par), .req_multi(req_multi),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .tgt_req(tgt_req), .tgt_addr(tgt_addr),
        .tgt_cmd(tgt_cmd), .tgt_data(tgt_data), .tgt_be_n(tgt_be_n), .tgt_par(tgt_par),
        .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_retry(tgt_rsp_retry), .serr(serr)
    );

    always @(negedge clk) if (serr === 1'b1) serr_cnt++;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic req(input logic [AW-1:0] a, input logic [3:0] c, input logic [31:0] d,
                       input logic [3:0] be, input bit m, input logic [1:0] exp, input string tag);
        @(negedge clk);
        req_addr = a; req_cmd = c; req_data = d; req_be_n = be; req_multi = m;
        req_par = ^d; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check({tag, " rsp_valid"}, rsp_valid, 1);
        check({tag, " rsp_code"}, rsp_code, exp);
    endtask

    task automatic serve(input bit rt, input logic [AW-1:0] a, input string tag);
        int w = 0;
        @(negedge clk);
        while (!tgt_req && w < 60) begin
            @(negedge clk);
            w++;
        end
        check({tag, " issued"}, tgt_req, 1);
        check({tag, " addr"}, tgt_addr, a);
        tgt_rsp_valid = 1'b1; tgt_rsp_retry = rt;
        @(posedge clk); #1;
        tgt_rsp_valid = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (tgt_req) seen = 1'b1;
        end
        check({tag, " no issue"}, seen, 0);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 tgt_req", tgt_req, 0);
        check("R1 serr", serr, 0);
        order_ok = 1'b1;
        quiet(5, "R1 empty");
        order_ok = 1'b0;

        // R2/R5: new request retried, held back by ordering
        req(16'h0100, IOW, 32'hA5A5_1234, 4'b0000, 0, 2'b00, "R2 new");
        quiet(8, "R5 order gate");
        req(16'h0100, IOW, 32'hA5A5_1234, 4'b0000, 0, 2'b00, "R4 repeat pending");
        order_ok = 1'b1;
        wait_cyc(3);
        check("R5 tgt_req", tgt_req, 1);
        check("R5 tgt_cmd", tgt_cmd, IOW);
        check("R5 tgt_data", tgt_data, 32'hA5A5_1234);
        check("R5 tgt_be_n", tgt_be_n, 4'b0000);
        check("R5 tgt_par", tgt_par, ^32'hA5A5_1234);
        serve(0, 16'h0100, "R5 first");
        req(16'h0100, IOW, 32'hA5A5_1234, 4'b0000, 0, 2'b01, "R7 collect");
        quiet(6, "R4 single entry");

        // R9/R7: enabled-byte mismatch, then multi collect
        req(16'h0200, CFW, 32'h0BAD_F00D, 4'b0000, 0, 2'b00, "R2 cfg");
        serve(0, 16'h0200, "R5 cfg");
        req(16'h0200, CFW, 32'h0BAD_F10D, 4'b0000, 0, 2'b00, "R9 mismatch");
        req(16'h0200, CFW, 32'h0BAD_F00D, 4'b0000, 1, 2'b10, "R7 stop");
        quiet(6, "R9 no extra entry");

        // R8: sweep of every byte-enable pattern
        for (int be = 0; be < 16; be++) begin
            logic [31:0] dis_mask, d0, flip_en;
            logic [AW-1:0] a;
            a = 16'h1000 + AW'(be * 4);
            d0 = 32'h1357_9BDF ^ (32'h0101_0101 * be);
            dis_mask = '0;
            flip_en = '0;
            for (int b = 3; b >= 0; b--) begin
                if (be[b]) dis_mask[8*b +: 8] = 8'hFF;
                else flip_en = 32'h1 << (8 * b);
            end
            req(a, IOW, d0, 4'(be), 0, 2'b00, "R2 sweep new");
            serve(0, a, "R5 sweep");
            if (be != 15)
                req(a, IOW, d0 ^ flip_en, 4'(be), 0, 2'b00, "R9 sweep enabled diff");
            req(a, IOW, d0 ^ dis_mask, 4'(be), 0, 2'b01, "R8 sweep disabled diff");
        end

        // R8: read command ignores data
        req(16'h0300, IOR, 32'h1111_1111, 4'b0000, 0, 2'b00, "R2 read");
        serve(0, 16'h0300, "R5 read");
        req(16'h0300, IOR, 32'h2222_2222, 4'b0000, 0, 2'b01, "R8 read no data compare");

        // R3/R4/R5: fill, overflow, duplicate, order
        order_ok = 1'b0;
        for (int i = 0; i < 4; i++)
            req(16'h2000 + AW'(i * 4), IOW, 32'hC0DE_0000 + i, 4'b0000, 0, 2'b00, "R2 fill");
        req(16'h2010, IOW, 32'hDEAD_0000, 4'b0000, 0, 2'b00, "R3 full");
        req(16'h2000, IOW, 32'hFFFF_FFFF, 4'b0000, 0, 2'b00, "R4 dup");
        order_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            serve(0, 16'h2000 + AW'(i * 4), "R5 fifo order");
            req(16'h2000 + AW'(i * 4), IOW, 32'hC0DE_0000 + i, 4'b0000, 0, 2'b01, "R7 fifo collect");
        end
        quiet(6, "R3 overflow not stored");

        // R6: attempt limit with error enabled
        serr_en = 1'b1;
        base = serr_cnt;
        req(16'h4000, IOW, 32'h4444_0000, 4'b0000, 0, 2'b00, "R2 limit");
        for (int i = 0; i < 8; i++) serve(1, 16'h4000, "R6 reissue");
        wait_cyc(3);
        check("R6 serr pulse", serr_cnt, base + 1);
        quiet(5, "R6 no more attempts");
        req(16'h4000, IOW, 32'h4444_0000, 4'b0000, 0, 2'b11, "R6 abort");
        quiet(5, "R6 entry removed");

        // R11: attempt limit with error disabled
        serr_en = 1'b0;
        base = serr_cnt;
        req(16'h4100, IOW, 32'h4444_0001, 4'b0000, 0, 2'b00, "R2 limit2");
        for (int i = 0; i < 8; i++) serve(1, 16'h4100, "R6 reissue2");
        wait_cyc(3);
        check("R11 serr masked", serr_cnt, base);
        req(16'h4100, IOW, 32'h4444_0001, 4'b0000, 0, 2'b11, "R6 abort2");

        // R10: short discard period
        serr_en = 1'b1;
        discard_short = 1'b1;
        base = serr_cnt;
        req(16'h5000, IOW, 32'h5555_0000, 4'b0000, 0, 2'b00, "R2 disc");
        serve(0, 16'h5000, "R5 disc");
        wait_cyc(20);
        check("R10 short discard serr", serr_cnt, base + 1);
        req(16'h5000, IOW, 32'h5555_0000, 4'b0000, 0, 2'b00, "R10 treated as new");
        serve(0, 16'h5000, "R10 re-stored");
        wait_cyc(10);
        req(16'h5000, IOW, 32'h5555_0000, 4'b0000, 0, 2'b01, "R10 within short");

        // R10: long discard period
        discard_short = 1'b0;
        base = serr_cnt;
        req(16'h5100, IOW, 32'h5555_0001, 4'b0000, 0, 2'b00, "R2 long");
        serve(0, 16'h5100, "R5 long");
        wait_cyc(40);
        req(16'h5100, IOW, 32'h5555_0001, 4'b0000, 0, 2'b01, "R10 within long");
        check("R10 no discard serr", serr_cnt, base);
        req(16'h5200, IOW, 32'h5555_0002, 4'b0000, 0, 2'b00, "R2 long2");
        serve(0, 16'h5200, "R5 long2");
        wait_cyc(70);
        check("R10 long discard serr", serr_cnt, base + 1);
        req(16'h5200, IOW, 32'h5555_0002, 4'b0000, 0, 2'b00, "R10 long treated new");
        serve(0, 16'h5200, "R10 long re-stored");
        req(16'h5200, IOW, 32'h5555_0002, 4'b0000, 0, 2'b01, "R7 final collect");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule